// File: doc/BRIEF.md
# Programmable Clock Generator Divider

This block turns one slow oscillator clock into a divided output that can drive a watchdog counter. It counts oscillator cycles, and it produces either a one-cycle pulse per period (for use as a clock enable) or a square wave near 50% duty (for use as a clock). Software sets four controls from a separate host clock domain:

- the division field;
- a mode bit that picks a linear divisor or a power-of-two divisor;
- a duty-correction bit;
- a run bit that turns the generator on and off.

Each accepted write is held in the host domain and announced to the oscillator domain with a toggle. The new setting waits for the end of the current output period, and a confirming toggle then returns to the host. The host sees a busy flag for the whole of that exchange. While the flag is high, further writes are dropped. This keeps the held setting stable while the other domain samples it.

The parameter `CNT_W` sets the width of the period counter and must be larger than the 8-bit division field. The parameter `SYNC_N` sets the number of synchronizer stages in each direction and must be at least 2.

Top module: `clkgen_div`

## Requirements
- R1: After both synchronous resets, `busy` is low, `gen_out` is low and the generator is stopped.
- R2: With `cfg_exp`=0 the period is `cfg_div` oscillator cycles, and a `cfg_div` of 0 or 1 gives a period of one cycle (no division).
- R3: With `cfg_exp`=1 the period is 2^(N+1) oscillator cycles, where N is `cfg_div` limited to at most `CNT_W`-1. For example, N=4 divides by 32.
- R4: While the applied setting has `cfg_run`=0, `gen_out` is held low. A later enable starts a fresh period.
- R5: With `cfg_half`=0, `gen_out` is high for exactly the first oscillator cycle of each period.
- R6: With `cfg_half`=1, `gen_out` is high for the first ceil(P/2) cycles of a period of P cycles and low for the rest. This is exactly 50% whenever P is even.
- R7: The host cycle after an accepted write, `busy` rises. Timing in the oscillator domain:
  - the write is seen at the (`SYNC_N`+1)th oscillator edge after the accepting host edge;
  - it is applied at the first later oscillator edge that ends a period, or at once if the generator is stopped.
  
  `busy` then falls at the `SYNC_N`th host edge after that applying edge.
- R8: A write presented while `busy` is high is ignored. Neither the output nor the busy timing changes.
- R9: A running period is never cut short. A new setting takes effect only at the edge that ends the current period, and if the new setting runs, its first cycle drives `gen_out` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst | input | 1 | Host-domain synchronous reset, active high |
| wr_en | input | 1 | Configuration write strobe |
| cfg_div | input | 8 | Division field N |
| cfg_exp | input | 1 | 1 = power-of-two divisor, 0 = linear divisor |
| cfg_half | input | 1 | Duty correction enable |
| cfg_run | input | 1 | Generator enable |
| busy | output | 1 | High while a write is being carried across and applied |
| src_clk | input | 1 | Slow oscillator clock |
| src_rst | input | 1 | Oscillator-domain synchronous reset, active high |
| gen_out | output | 1 | Divided output, registered in the oscillator domain |

## Verification
The bench keeps a behavioural model of both clock domains. It compares `gen_out` on every oscillator cycle and `busy` on every host cycle, so any error in timing is reported in the cycle where it occurs.

It covers the following corner cases:
- Division fields of 0 and 1, which must not divide. An off-by-one counter would produce a period of 2 here.
- Odd periods with duty correction, which show whether the high phase is rounded up or down.
- An exponent above the counter width. A design that does not clamp it would wrap the counter.
- A setting written in the middle of a long period. A design that applies it early would produce a runt period, and `busy` would fall too soon.
- A second write issued while `busy` is high. Accepting it would replace the held setting in the middle of a transfer and change the divisor that is finally applied.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int unsigned DIV_W = 8;

    typedef struct packed {
        logic             run;
        logic             half;
        logic             expo;
        logic [DIV_W-1:0] div;
    } gen_cfg_t;

    localparam gen_cfg_t CFG_IDLE = '0;

    // Last count value of one output period (period length minus one).
    function automatic logic [31:0] period_last(gen_cfg_t c, int unsigned cnt_w);
        logic [31:0] e;
        if (c.expo) begin
            e = (32'(c.div) > cnt_w - 1) ? 32'(cnt_w - 1) : 32'(c.div);
            return (32'd1 << (e + 32'd1)) - 32'd1;
        end
        return (c.div < DIV_W'(2)) ? 32'd0 : 32'(c.div) - 32'd1;
    endfunction

    // Output level for a given count within the period.
    function automatic logic level_for(gen_cfg_t c, logic [31:0] cnt, logic [31:0] last);
        return c.run && (c.half ? (cnt <= (last >> 1)) : (cnt == 32'd0));
    endfunction

endpackage

// File: rtl/clkgen_host.sv
module clkgen_host
    import clkgen_pkg::*;
#(
    parameter int unsigned SYNC_N = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  gen_cfg_t wr_cfg,
    input  logic     ack_tgl,
    output gen_cfg_t hold,
    output logic     req_tgl,
    output logic     busy
);

    logic [SYNC_N-1:0] ack_sync;

    assign busy = req_tgl ^ ack_sync[SYNC_N-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            hold     <= CFG_IDLE;
            req_tgl  <= 1'b0;
            ack_sync <= '0;
        end else begin
            ack_sync <= {ack_sync[SYNC_N-2:0], ack_tgl};
            if (wr_en && !busy) begin
                hold    <= wr_cfg;
                req_tgl <= ~req_tgl;
            end
        end
    end

    AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy) |=> busy); // R7

    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> $stable(hold)); // R8

endmodule

// File: rtl/clkgen_sync.sv
module clkgen_sync
    import clkgen_pkg::*;
#(
    parameter int unsigned SYNC_N = 2
) (
    input  logic     src_clk,
    input  logic     src_rst,
    input  logic     req_tgl,
    input  gen_cfg_t hold,
    input  logic     take,
    output logic     pend_valid,
    output gen_cfg_t pend_cfg,
    output logic     ack_tgl
);

    logic [SYNC_N-1:0] req_sync;
    logic              req_seen;
    logic              new_req;

    assign new_req = req_sync[SYNC_N-1] ^ req_seen;

    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            req_sync   <= '0;
            req_seen   <= 1'b0;
            pend_valid <= 1'b0;
            pend_cfg   <= CFG_IDLE;
            ack_tgl    <= 1'b0;
        end else begin
            req_sync <= {req_sync[SYNC_N-2:0], req_tgl};
            req_seen <= req_sync[SYNC_N-1];
            if (new_req) begin
                pend_valid <= 1'b1;
                pend_cfg   <= hold;
            end else if (take) begin
                pend_valid <= 1'b0;
                ack_tgl    <= ~ack_tgl;
            end
        end
    end

    AST_NO_REQ_OVERLAP: assert property (@(posedge src_clk) disable iff (src_rst)
        new_req |-> !pend_valid); // R8

    AST_TAKE_NEEDS_PEND: assert property (@(posedge src_clk) disable iff (src_rst)
        take |-> pend_valid); // R7

endmodule

// File: rtl/clkgen_core.sv
module clkgen_core
    import clkgen_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic     src_clk,
    input  logic     src_rst,
    input  logic     pend_valid,
    input  gen_cfg_t pend_cfg,
    output logic     take,
    output logic     gen_out
);

    gen_cfg_t         act;
    gen_cfg_t         nxt_act;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt_cnt;
    logic [CNT_W-1:0] last_cur;
    logic [CNT_W-1:0] last_nxt;
    logic             at_end;
    logic             nxt_out;

    always_comb begin
        last_cur = CNT_W'(period_last(act, CNT_W));
        at_end   = (cnt == last_cur);
        take     = pend_valid && (!act.run || at_end);
        nxt_act  = take ? pend_cfg : act;
        if (take || !act.run || at_end) begin
            nxt_cnt = '0;
        end else begin
            nxt_cnt = cnt + 1'b1;
        end
        last_nxt = CNT_W'(period_last(nxt_act, CNT_W));
        nxt_out  = level_for(nxt_act, 32'(nxt_cnt), 32'(last_nxt));
    end

    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            act     <= CFG_IDLE;
            cnt     <= '0;
            gen_out <= 1'b0;
        end else begin
            act     <= nxt_act;
            cnt     <= nxt_cnt;
            gen_out <= nxt_out;
        end
    end

    AST_STOPPED_LOW: assert property (@(posedge src_clk) disable iff (src_rst)
        !act.run |-> !gen_out); // R4

    AST_CNT_RANGE: assert property (@(posedge src_clk) disable iff (src_rst)
        cnt <= last_cur); // R2

    AST_SINGLE_PULSE: assert property (@(posedge src_clk) disable iff (src_rst)
        (act.run && !act.half && gen_out && last_cur != '0) |=> !gen_out); // R5

    AST_NO_MIDPERIOD_SWITCH: assert property (@(posedge src_clk) disable iff (src_rst)
        (act.run && cnt != last_cur) |=> $stable(act)); // R9

    AST_PERIOD_START_HIGH: assert property (@(posedge src_clk) disable iff (src_rst)
        (take && pend_cfg.run) |=> gen_out); // R9

endmodule

// File: rtl/clkgen_div.sv
module clkgen_div
    import clkgen_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_exp,
    input  logic             cfg_half,
    input  logic             cfg_run,
    output logic             busy,
    input  logic             src_clk,
    input  logic             src_rst,
    output logic             gen_out
);

    gen_cfg_t wr_cfg;
    gen_cfg_t hold;
    gen_cfg_t pend_cfg;
    logic     req_tgl;
    logic     ack_tgl;
    logic     pend_valid;
    logic     take;

    assign wr_cfg = '{run: cfg_run, half: cfg_half, expo: cfg_exp, div: cfg_div};

    clkgen_host #(.SYNC_N(SYNC_N)) u_host (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_cfg  (wr_cfg),
        .ack_tgl (ack_tgl),
        .hold    (hold),
        .req_tgl (req_tgl),
        .busy    (busy)
    );

    clkgen_sync #(.SYNC_N(SYNC_N)) u_sync (
        .src_clk    (src_clk),
        .src_rst    (src_rst),
        .req_tgl    (req_tgl),
        .hold       (hold),
        .take       (take),
        .pend_valid (pend_valid),
        .pend_cfg   (pend_cfg),
        .ack_tgl    (ack_tgl)
    );

    clkgen_core #(.CNT_W(CNT_W)) u_core (
        .src_clk    (src_clk),
        .src_rst    (src_rst),
        .pend_valid (pend_valid),
        .pend_cfg   (pend_cfg),
        .take       (take),
        .gen_out    (gen_out)
    );

endmodule

// File: tb/clkgen_div_test.sv
module clkgen_div_test;

    localparam int HOST_PERIOD = 10;
    localparam int SRC_PERIOD  = 40;
    localparam int CNT_W_TB    = 10;
    localparam int SYNC_TB     = 2;
    localparam int WD_LIMIT    = 150000;
    localparam int IDLE_LIMIT  = 6000;

    logic       clk = 1'b0;
    logic       src_clk = 1'b0;
    logic       rst = 1'b1;
    logic       src_rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] cfg_div = '0;
    logic       cfg_exp = 1'b0;
    logic       cfg_half = 1'b0;
    logic       cfg_run = 1'b0;
    logic       busy;
    logic       gen_out;

    clkgen_div #(.CNT_W(CNT_W_TB), .SYNC_N(SYNC_TB)) uut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .cfg_div  (cfg_div),
        .cfg_exp  (cfg_exp),
        .cfg_half (cfg_half),
        .cfg_run  (cfg_run),
        .busy     (busy),
        .src_clk  (src_clk),
        .src_rst  (src_rst),
        .gen_out  (gen_out)
    );

    always #(HOST_PERIOD/2) clk = ~clk;
    initial begin
        #2;
        forever #(SRC_PERIOD/2) src_clk = ~src_clk;
    end

    typedef struct {
        int dv;
        bit ex;
        bit hf;
        bit rn;
    } mcfg_t;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    wd = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    bit    m_busy, m_inflight, m_ack_arm, m_pend, m_out;
    int    m_age, m_ack_cnt, m_cnt, m_per;
    mcfg_t m_h, m_p, m_a;

    function automatic int ref_period(mcfg_t c);
        int e;
        if (c.ex) begin
            e = (c.dv > CNT_W_TB - 1) ? CNT_W_TB - 1 : c.dv;
            return 1 << (e + 1);
        end
        return (c.dv < 2) ? 1 : c.dv;
    endfunction

    function automatic bit ref_level(mcfg_t c, int cnt);
        int p;
        p = ref_period(c);
        if (!c.rn) return 1'b0;
        if (c.hf) return cnt < (p + 1) / 2;
        return cnt == 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy     = 1'b0;
            m_inflight = 1'b0;
            m_ack_arm  = 1'b0;
            m_h        = '{0, 1'b0, 1'b0, 1'b0};
        end else if (m_ack_arm) begin
            m_ack_cnt++;
            if (m_ack_cnt == SYNC_TB) begin
                m_busy    = 1'b0;
                m_ack_arm = 1'b0;
            end
        end else if (wr_en && !m_busy) begin
            m_busy     = 1'b1;
            m_h        = '{int'(cfg_div), cfg_exp, cfg_half, cfg_run};
            m_inflight = 1'b1;
            m_age      = 0;
        end
    end

    always @(posedge src_clk) begin
        if (src_rst) begin
            m_pend = 1'b0;
            m_a    = '{0, 1'b0, 1'b0, 1'b0};
            m_cnt  = 0;
            m_out  = 1'b0;
        end else begin
            m_per = ref_period(m_a);
            if (m_pend && (!m_a.rn || m_cnt == m_per - 1)) begin
                m_a       = m_p;
                m_cnt     = 0;
                m_pend    = 1'b0;
                m_ack_arm = 1'b1;
                m_ack_cnt = 0;
            end else if (m_a.rn) begin
                m_cnt = (m_cnt == m_per - 1) ? 0 : m_cnt + 1;
            end else begin
                m_cnt = 0;
            end
            if (m_inflight) begin
                m_age++;
                if (m_age == SYNC_TB + 1) begin
                    m_pend     = 1'b1;
                    m_p        = m_h;
                    m_inflight = 1'b0;
                end
            end
            m_out = ref_level(m_a, m_cnt);
        end
    end

    task automatic check(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    always @(negedge src_clk) begin
        if (chk_on) check({cur_req, " gen_out"}, gen_out, m_out);
    end

    always @(negedge clk) begin
        if (chk_on) check("R7 busy", busy, m_busy);
    end

    always @(posedge clk) begin
        wd++;
        if (wd > WD_LIMIT && !done) begin
            n_bad++;
            $display("FAIL watchdog (R1..R9 run): actual %0d cycles expected below %0d", wd, WD_LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic write_cfg(int dv, bit ex, bit hf, bit rn);
        @(negedge clk);
        wr_en    = 1'b1;
        cfg_div  = 8'(dv);
        cfg_exp  = ex;
        cfg_half = hf;
        cfg_run  = rn;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int k;
        k = 0;
        while (busy !== 1'b0 && k < IDLE_LIMIT) begin
            @(negedge clk);
            k++;
        end
        if (k >= IDLE_LIMIT) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R7 busy stuck: actual 1 expected 0 within %0d cycles", IDLE_LIMIT);
        end
    endtask

    task automatic program_cfg(int dv, bit ex, bit hf, bit rn);
        write_cfg(dv, ex, hf, rn);
        wait_idle();
    endtask

    task automatic run_src(int n);
        repeat (n) @(negedge src_clk);
    endtask

    initial begin
        repeat (4) @(negedge src_clk);
        rst     = 1'b0;
        src_rst = 1'b0;
        @(negedge clk);
        chk_on = 1'b1;
        // R1: reset state
        check("R1 busy after reset", busy, 1'b0);
        check("R1 gen_out after reset", gen_out, 1'b0);

        cur_req = "R4";
        run_src(12);

        cur_req = "R2";
        program_cfg(5, 1'b0, 1'b0, 1'b1);
        run_src(20);
        program_cfg(0, 1'b0, 1'b0, 1'b1);
        run_src(6);
        program_cfg(1, 1'b0, 1'b0, 1'b1);
        run_src(6);

        cur_req = "R5";
        program_cfg(7, 1'b0, 1'b0, 1'b1);
        run_src(22);

        cur_req = "R6";
        program_cfg(5, 1'b0, 1'b1, 1'b1);
        run_src(16);
        program_cfg(4, 1'b0, 1'b1, 1'b1);
        run_src(12);
        program_cfg(1, 1'b0, 1'b1, 1'b1);
        run_src(4);

        cur_req = "R3";
        program_cfg(4, 1'b1, 1'b0, 1'b1);
        run_src(70);
        program_cfg(4, 1'b1, 1'b1, 1'b1);
        run_src(70);
        program_cfg(0, 1'b1, 1'b1, 1'b1);
        run_src(8);
        program_cfg(200, 1'b1, 1'b1, 1'b1);
        run_src(2100);

        cur_req = "R9";
        program_cfg(200, 1'b0, 1'b0, 1'b1);
        run_src(50);
        write_cfg(3, 1'b0, 1'b1, 1'b1);
        run_src(170);
        wait_idle();
        run_src(10);

        cur_req = "R8";
        write_cfg(6, 1'b0, 1'b1, 1'b1);
        write_cfg(2, 1'b1, 1'b0, 1'b1);
        wait_idle();
        run_src(30);

        cur_req = "R4";
        program_cfg(9, 1'b0, 1'b0, 1'b0);
        run_src(20);
        program_cfg(3, 1'b0, 1'b0, 1'b1);
        run_src(10);
        write_cfg(6, 1'b0, 1'b1, 1'b0);
        wait_idle();
        run_src(15);

        chk_on = 1'b0;
        done   = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule